// File: doc/BRIEF.md
# Microcode Address Sequencer

This block produces the microcode address of a microprogrammed control unit, one step per clock. It holds the microcode store, a small program computed at elaboration, and reads it synchronously, so the address register and the microword register load together on every edge. Each microword names two possible successors: a next address and an alternate address. A condition-select code in the word decides which successor to take, based on status lines from the datapath. A dispatch bit replaces both with an entry point derived from the opcode.

Because every word names its own successor, an instruction's microcode may be any length. Several instructions can branch into the same shared routine, such as an operand-access sequence or the interrupt check that runs before each fetch. The control bits in the upper part of the microword go to the datapath, which is outside this block.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 and `uword` is all zero. After `rst_n` rises, the outputs hold for two more rising edges, and the third rising edge loads `uaddr` = 0 with `uword` = the store word at address 0.
- R2: Microword layout: bits [10:0] next address, [21:11] alternate address, [24:22] condition select, [25] dispatch, [31:26] datapath control.
- R3: When dispatch is 0, condition select picks the successor. Code 0 always takes next. Code 1 always takes alternate. Codes 2, 3, 4 and 5 take alternate when `cond_carry`, `cond_zero`, `irq_pend` or `cnt_zero` respectively is 1, and take next otherwise.
- R4: Condition-select codes 6 and 7 behave like code 0.
- R5: When dispatch is 1, the following address is 256 + `opcode`, whatever the condition select.
- R6: On every edge `uaddr` and `uword` update together, and `uword` equals the store content at `uaddr`. The branch decision uses the current `uword` and the condition inputs present in that same cycle.
- R7: Store contents, where ctrl is address bits [5:0] and all other fields are 0 unless stated:
  - address 0: select 4, next 1, alternate 8;
  - address 1: dispatch;
  - address 2: shared routine, select 0, next 0;
  - address 3: select 6, next 2, alternate 2047;
  - address 8: interrupt service, select 0, next 0;
  - every unlisted address outside 256..511 is all zero.
- R8: The entry at 256 + op has ctrl = op[5:0]. Its fields depend on op[1:0]:
  - 0: select 1, alternate 3, next 2047;
  - 1: select 2, alternate 2, next 0;
  - 2: select 3, alternate 2, next 0;
  - 3: select 5, alternate 2, next = its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_carry | input | 1 | Carry status from the datapath |
| cond_zero | input | 1 | Zero status from the datapath |
| irq_pend | input | 1 | Interrupt pending |
| cnt_zero | input | 1 | Loop counter has reached zero |
| opcode | input | 8 | Fetched opcode used by dispatch |
| uaddr | output | 11 | Current microcode address |
| uword | output | 32 | Registered microword read from `uaddr` |

## Verification
The embedded properties check the successor rule on every cycle. They cover the dispatch target, the fixed next and alternate codes, the reserved codes and the carry and loop-counter selections, each measured one edge after the word that caused it. The reset hold and its release latency can only be seen in the bench's scenarios. So can the pairing of each address with its stored word, and the walks through the program: fetch, dispatch, the shared routine, interrupt service and a counter loop that spins on its own entry.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned UA_W      = 11;
  localparam int unsigned UW_W      = 32;
  localparam int unsigned OP_W      = 8;
  localparam int unsigned CS_W      = 3;
  localparam int unsigned DISP_BASE = 256;
  localparam int unsigned CTRL_W    = UW_W - 2*UA_W - CS_W - 1;
  localparam int unsigned DEPTH     = 1 << UA_W;

  typedef enum logic [CS_W-1:0] {
    CS_NEXT  = 3'd0,
    CS_ALT   = 3'd1,
    CS_CARRY = 3'd2,
    CS_ZERO  = 3'd3,
    CS_IRQ   = 3'd4,
    CS_CNTZ  = 3'd5,
    CS_RSV6  = 3'd6,
    CS_RSV7  = 3'd7
  } cond_sel_e;

  // R2: field order from the top bit down
  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              disp;
    cond_sel_e         cs;
    logic [UA_W-1:0]   alt;
    logic [UA_W-1:0]   nxt;
  } uword_t;

  // R7 R8: microprogram computed from the address
  function automatic uword_t rom_word(input int unsigned a);
    uword_t          w;
    logic [UA_W-1:0] self_a;
    logic [UA_W-1:0] top_a;
    logic [1:0]      cls;
    w      = '0;
    self_a = UA_W'(a);
    top_a  = '1;
    cls    = 2'(a - DISP_BASE);
    if (a == 0) begin
      w.cs  = CS_IRQ;
      w.nxt = UA_W'(1);
      w.alt = UA_W'(8);
    end else if (a == 1) begin
      w.ctrl = self_a[CTRL_W-1:0];
      w.disp = 1'b1;
    end else if (a == 2 || a == 8) begin
      w.ctrl = self_a[CTRL_W-1:0];
    end else if (a == 3) begin
      w.ctrl = self_a[CTRL_W-1:0];
      w.cs   = CS_RSV6;
      w.nxt  = UA_W'(2);
      w.alt  = top_a;
    end else if (a >= DISP_BASE && a < DISP_BASE + (1 << OP_W)) begin
      w.ctrl = self_a[CTRL_W-1:0];
      case (cls)
        2'd0: begin w.cs = CS_ALT;   w.alt = UA_W'(3); w.nxt = top_a;  end
        2'd1: begin w.cs = CS_CARRY; w.alt = UA_W'(2); w.nxt = '0;     end
        2'd2: begin w.cs = CS_ZERO;  w.alt = UA_W'(2); w.nxt = '0;     end
        default: begin w.cs = CS_CNTZ; w.alt = UA_W'(2); w.nxt = self_a; end
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  // R1: asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int unsigned AW = UA_W,
  parameter int unsigned OW = OP_W
) (
  input  uword_t          cur,
  input  logic            carry,
  input  logic            zero,
  input  logic            irq,
  input  logic            cntz,
  input  logic [OW-1:0]   opcode,
  output logic [AW-1:0]   nxt_addr
);
  logic take_alt;

  // R3 R4: condition select
  always_comb begin
    case (cur.cs)
      CS_ALT:   take_alt = 1'b1;
      CS_CARRY: take_alt = carry;
      CS_ZERO:  take_alt = zero;
      CS_IRQ:   take_alt = irq;
      CS_CNTZ:  take_alt = cntz;
      default:  take_alt = 1'b0;
    endcase
  end

  // R5: dispatch overrides both fields
  always_comb begin
    if (cur.disp)
      nxt_addr = AW'(DISP_BASE) + AW'(opcode);
    else if (take_alt)
      nxt_addr = cur.alt;
    else
      nxt_addr = cur.nxt;
  end
endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned AW = UA_W,
  parameter int unsigned WW = UW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output uword_t        word_q
);
  localparam int unsigned ND = 1 << AW;

  logic [WW-1:0] mem [ND];
  uword_t        word_d;

  for (genvar gi = 0; gi < ND; gi++) begin : g_store
    assign mem[gi] = WW'(rom_word(gi));
  end

  // R6: synchronous read in step with the address register
  always_comb begin
    word_d = word_q;
    if (rd_en) word_d = uword_t'(mem[rd_addr]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int unsigned AW = UA_W,
  parameter int unsigned WW = UW_W,
  parameter int unsigned OW = OP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cond_carry,
  input  logic          cond_zero,
  input  logic          irq_pend,
  input  logic          cnt_zero,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] uaddr,
  output logic [WW-1:0] uword
);
  logic          rst_q;
  logic          step_en;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] uaddr_d;
  logic [AW-1:0] uaddr_q;
  uword_t        cur;

  useq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  useq_next_addr #(.AW(AW), .OW(OW)) u_next (
    .cur      (cur),
    .carry    (cond_carry),
    .zero     (cond_zero),
    .irq      (irq_pend),
    .cntz     (cnt_zero),
    .opcode   (opcode),
    .nxt_addr (nxt_addr)
  );

  useq_rom #(.AW(AW), .WW(WW)) u_rom (
    .clk     (clk),
    .rst_n   (rst_q),
    .rd_en   (step_en),
    .rd_addr (nxt_addr),
    .word_q  (cur)
  );

  assign step_en = 1'b1;

  always_comb begin
    uaddr_d = uaddr_q;
    if (step_en) uaddr_d = nxt_addr;
  end

  // R1: reset value 0
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) uaddr_q <= '0;
    else        uaddr_q <= uaddr_d;
  end

  assign uaddr = uaddr_q;
  assign uword = WW'(cur);

  AST_DISPATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_q)
    cur.disp |=> uaddr == AW'(DISP_BASE) + AW'($past(opcode))); // R5

  AST_FIXED_NEXT: assert property (@(posedge clk) disable iff (!rst_q)
    (!cur.disp && cur.cs == CS_NEXT) |=> uaddr == $past(cur.nxt)); // R3

  AST_RESERVED_NEXT: assert property (@(posedge clk) disable iff (!rst_q)
    (!cur.disp && (cur.cs == CS_RSV6 || cur.cs == CS_RSV7)) |=> uaddr == $past(cur.nxt)); // R4

  AST_FIXED_ALT: assert property (@(posedge clk) disable iff (!rst_q)
    (!cur.disp && cur.cs == CS_ALT) |=> uaddr == $past(cur.alt)); // R3

  AST_CARRY_PICK: assert property (@(posedge clk) disable iff (!rst_q)
    (!cur.disp && cur.cs == CS_CARRY) |=>
      uaddr == ($past(cond_carry) ? $past(cur.alt) : $past(cur.nxt))); // R3

  AST_COUNTER_PICK: assert property (@(posedge clk) disable iff (!rst_q)
    (!cur.disp && cur.cs == CS_CNTZ) |=>
      uaddr == ($past(cnt_zero) ? $past(cur.alt) : $past(cur.nxt))); // R3
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cond_carry, cond_zero, irq_pend, cnt_zero;
  logic [7:0]  opcode;
  logic [10:0] uaddr;
  logic [31:0] uword;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    logic [10:0] a;
    logic [31:0] w;
    int          kind;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_word;

  always #2 clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cond_carry(cond_carry), .cond_zero(cond_zero),
    .irq_pend(irq_pend), .cnt_zero(cnt_zero), .opcode(opcode),
    .uaddr(uaddr), .uword(uword)
  );

  // R2 layout: {ctrl[5:0], disp, sel[2:0], alt[10:0], next[10:0]}
  function automatic logic [31:0] pk(input logic [5:0] c, input logic d,
                                     input logic [2:0] s, input logic [10:0] al,
                                     input logic [10:0] nx);
    return {c, d, s, al, nx};
  endfunction

  // R7 R8 program as stated in the requirements
  function automatic logic [31:0] mw(input int a);
    logic [10:0] aa;
    aa = 11'(a);
    if (a == 0) return pk(6'd0, 1'b0, 3'd4, 11'd8, 11'd1);
    if (a == 1) return pk(6'd1, 1'b1, 3'd0, 11'd0, 11'd0);
    if (a == 2) return pk(6'd2, 1'b0, 3'd0, 11'd0, 11'd0);
    if (a == 3) return pk(6'd3, 1'b0, 3'd6, 11'h7FF, 11'd2);
    if (a == 8) return pk(6'd8, 1'b0, 3'd0, 11'd0, 11'd0);
    if (a >= 256 && a < 512) begin
      case (a % 4)
        0: return pk(aa[5:0], 1'b0, 3'd1, 11'd3, 11'h7FF);
        1: return pk(aa[5:0], 1'b0, 3'd2, 11'd2, 11'd0);
        2: return pk(aa[5:0], 1'b0, 3'd3, 11'd2, 11'd0);
        default: return pk(aa[5:0], 1'b0, 3'd5, 11'd2, aa);
      endcase
    end
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply inputs, predict successor, push expectation
  task automatic step(input logic c, input logic z, input logic i,
                      input logic cz, input logic [7:0] op);
    exp_t        e;
    logic        alt_pick;
    logic [10:0] nx;
    logic [2:0]  s;
    cond_carry = c; cond_zero = z; irq_pend = i; cnt_zero = cz; opcode = op;
    s = m_word[24:22];
    case (s)
      3'd1: alt_pick = 1'b1;
      3'd2: alt_pick = c;
      3'd3: alt_pick = z;
      3'd4: alt_pick = i;
      3'd5: alt_pick = cz;
      default: alt_pick = 1'b0;
    endcase
    if (m_word[25]) begin
      nx = 11'd256 + {3'd0, op};
      e.kind = 5;
    end else begin
      nx = alt_pick ? m_word[21:11] : m_word[10:0];
      e.kind = (s >= 3'd6) ? 4 : 3;
    end
    m_word = mw(int'(nx));
    e.due = cyc + 1;
    e.a   = nx;
    e.w   = m_word;
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int n, input logic c, input logic z, input logic i,
                     input logic cz, input logic [7:0] op);
    for (int k = 0; k < n; k++) step(c, z, i, cz, op);
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    cyc++;
    #3;
    if (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      if (e.kind == 5)      chk(uaddr == e.a, "R5", 32'(uaddr), 32'(e.a));
      else if (e.kind == 4) chk(uaddr == e.a, "R4", 32'(uaddr), 32'(e.a));
      else                  chk(uaddr == e.a, "R3", 32'(uaddr), 32'(e.a));
      chk(uword == e.w, "R6/R7/R8", uword, e.w);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_word = 32'd0;
    rst_n = 1'b0;
    cond_carry = 1'b0; cond_zero = 1'b0; irq_pend = 1'b0; cnt_zero = 1'b0;
    opcode = 8'd0;
    repeat (3) @(posedge clk);
    #1;
    chk(uaddr == 11'd0, "R1", 32'(uaddr), 32'd0);
    chk(uword == 32'd0, "R1", uword, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(uaddr == 11'd0 && uword == 32'd0, "R1", uword, 32'd0);
    @(posedge clk); #1;
    chk(uaddr == 11'd0 && uword == 32'd0, "R1", uword, 32'd0);
    // first active edge: address 0 with its stored word (R1)
    run(6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04);  // class 0: always-alt, reserved select
    run(6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05);  // carry taken
    run(6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09);  // carry not taken
    run(6, 1'b0, 1'b1, 1'b0, 1'b0, 8'h06);  // zero taken
    run(6, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFE);  // zero not taken, top opcode
    run(8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07);  // loop on own entry
    run(3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h07);  // counter done
    run(4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);  // interrupt service
    run(4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2] & r[3], r[4], r[15:8]);
    end
    repeat (3) @(posedge clk);
    #4;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule